// File: doc/BRIEF.md
# Interrupt Controller Register Interface

This block is the memory-mapped register slave of a platform interrupt controller. Software reaches the controller's programmable state through it: a priority level for each interrupt source, read-only words that reflect the sources currently pending, per-context enable words, and, for each context, a threshold register and a claim/complete register. The block stores priorities, thresholds and enables and drives them out as flat vectors. The arbitration logic is a separate unit that consumes these vectors and produces the pending bits and the claim answers.

Requests arrive on a plain valid/write/address/data interface. Every request receives a response exactly one clock later, with read data and an error flag. A read of a context's claim register raises a one-cycle claim pulse toward the arbiter in the request cycle. The arbiter answers in the same cycle, and that answer becomes the read data. A write to the same register raises a one-cycle completion pulse that carries the context and the source id written.

Priority and threshold values obey a legality rule set by the maximum priority. When the maximum plus one is a power of two, the excess bits of a written value are dropped. Otherwise an out-of-range value is refused and the old value stays.

Top module: `irqc_reg_if`

## Requirements
- R1: The priority of source n, for 1 ≤ n < NSRC, is read and written at PRIO_BASE + 4·(n−1). It appears on `prio_o[n*PW +: PW]`. Slot 0 of `prio_o` is always 0.
- R2: When MAX_PRIO+1 is a power of two, a priority or threshold write stores the written value modulo MAX_PRIO+1.
- R3: When MAX_PRIO+1 is not a power of two, a priority or threshold write of a value above MAX_PRIO is discarded and the old value is kept. A value up to MAX_PRIO is stored as written.
- R4: The threshold of context c is read and written at CTX_BASE + c·CTX_STRIDE + 0. It appears on `thresh_o[c*PW +: PW]`.
- R5: Pending word w, at PEND_BASE + 4·w for w < ceil(NSRC/32), reads bit b as `pend_i[32w+b]`. Bit 0 of word 0 and bits at or above NSRC read 0. A write there changes nothing and sets `rsp_err`.
- R6: Enable word w of context c, at ENA_BASE + c·ENA_STRIDE + 4·w, is a full 32-bit read/write register. Bit b drives `enable_o[(c·NW + w)·32 + b]`. A word index w ≥ NW reads 0, ignores writes and sets `rsp_err`.
- R7: A read at CTX_BASE + c·CTX_STRIDE + 4 asserts `claim_o` with `claim_ctx_o` = c in the request cycle only. The response data is the zero-extended `claim_id_i` from that cycle.
- R8: A write of value v at that same offset asserts `complete_o` for one cycle, with `complete_ctx_o` = c and `complete_id_o` = v, when v < NSRC. When v ≥ NSRC there is no pulse and `rsp_err` is set.
- R9: Any other offset inside a context block reads 0, ignores writes and sets `rsp_err`.
- R10: A request gets `rsp_valid` in the next cycle only. A request is an error, reading 0 and writing nothing, in three cases: a misaligned address (addr[1:0] ≠ 0), an address outside every region, or any access flagged as an error in R5, R6, R8 or R9.
- R11: After reset all priorities, thresholds and enables are 0, and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Previous request was illegal or unmapped |
| pend_i | input | NSRC | Pending bit per source id from the gateway logic |
| claim_o | output | 1 | Claim pulse, request cycle of a claim read |
| claim_ctx_o | output | CTXW | Context being claimed |
| claim_id_i | input | IDW | Arbiter's winning source id for `claim_ctx_o` |
| complete_o | output | 1 | Completion pulse |
| complete_ctx_o | output | CTXW | Context completing |
| complete_id_o | output | IDW | Source id being completed |
| prio_o | output | NSRC·PW | Priority per source id |
| thresh_o | output | NCTX·PW | Threshold per context |
| enable_o | output | NCTX·NW·32 | Enable bits per context |

## Verification
The hardest case to reach is the refusal rule of R3. It cannot be seen at all when MAX_PRIO+1 is a power of two. The bench therefore drives two instances from the same request stream, one with a power-of-two maximum and one without, and compares each against its own model. Random priority data is drawn from a range wider than either maximum, so the folding path and the refusal path are both taken many times. Random addresses also cover enable words just past NW and context offsets other than 0 and 4.

// File: rtl/irqc_reg_pkg.sv
package irqc_reg_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_ENA,
        RG_THR,
        RG_CLAIM
    } region_e;

    typedef struct packed {
        logic        valid;
        logic        err;
        logic [31:0] data;
    } rsp_t;

    // true when maxp+1 is a power of two
    function automatic logic level_is_mask(input int unsigned maxp);
        return ((maxp + 1) & maxp) == 0;
    endfunction

    function automatic logic level_accept(input logic [31:0] v, input int unsigned maxp);
        return level_is_mask(maxp) ? 1'b1 : (v <= maxp);
    endfunction

    function automatic logic [31:0] level_fold(input logic [31:0] v, input int unsigned maxp);
        return level_is_mask(maxp) ? (v & maxp) : v;
    endfunction

endpackage

// File: rtl/irqc_addr_decode.sv
module irqc_addr_decode
    import irqc_reg_pkg::*;
#(
    parameter int unsigned NSRC       = 40,
    parameter int unsigned NCTX       = 2,
    parameter int unsigned NW         = 2,
    parameter int unsigned PRIO_BASE  = 32'h0000_0000,
    parameter int unsigned PEND_BASE  = 32'h0000_1000,
    parameter int unsigned ENA_BASE   = 32'h0000_2000,
    parameter int unsigned ENA_STRIDE = 32'h80,
    parameter int unsigned CTX_BASE   = 32'h0020_0000,
    parameter int unsigned CTX_STRIDE = 32'h1000,
    parameter int unsigned IDW        = 6,
    parameter int unsigned CTXW       = 1,
    parameter int unsigned WW         = 1
) (
    input  logic [31:0]     addr,
    output region_e         kind,
    output logic [IDW-1:0]  src_id,
    output logic [CTXW-1:0] ctx,
    output logic [WW-1:0]   word
);
    localparam logic [31:0] PRIO_SPAN = 32'(4 * (NSRC - 1));
    localparam logic [31:0] PEND_SPAN = 32'(4 * NW);
    localparam logic [31:0] ENA_SPAN  = 32'(NCTX * ENA_STRIDE);
    localparam logic [31:0] CTX_SPAN  = 32'(NCTX * CTX_STRIDE);
    localparam logic [31:0] ENA_MASK  = 32'(ENA_STRIDE - 1);
    localparam logic [31:0] CTX_MASK  = 32'(CTX_STRIDE - 1);
    localparam int unsigned ESH       = $clog2(ENA_STRIDE);
    localparam int unsigned CSH       = $clog2(CTX_STRIDE);

    logic [31:0] off_p, off_n, off_e, off_c, e_word, c_low, e_ctx, c_ctx;

    assign off_p  = addr - PRIO_BASE;
    assign off_n  = addr - PEND_BASE;
    assign off_e  = addr - ENA_BASE;
    assign off_c  = addr - CTX_BASE;
    assign e_word = (off_e & ENA_MASK) >> 2;
    assign c_low  = off_c & CTX_MASK;
    assign e_ctx  = off_e >> ESH;
    assign c_ctx  = off_c >> CSH;

    always_comb begin
        kind   = RG_NONE;
        src_id = '0;
        ctx    = '0;
        word   = '0;
        if (addr[1:0] != 2'b00) begin
            kind = RG_NONE;
        end else if (addr >= PRIO_BASE && off_p < PRIO_SPAN) begin
            kind   = RG_PRIO;
            src_id = IDW'((off_p >> 2) + 32'd1);
        end else if (addr >= PEND_BASE && off_n < PEND_SPAN) begin
            kind = RG_PEND;
            word = WW'(off_n >> 2);
        end else if (addr >= ENA_BASE && off_e < ENA_SPAN) begin
            ctx = CTXW'(e_ctx);
            if (e_word < NW) begin
                kind = RG_ENA;
                word = WW'(e_word);
            end
        end else if (addr >= CTX_BASE && off_c < CTX_SPAN) begin
            ctx = CTXW'(c_ctx);
            if (c_low == 32'd0)      kind = RG_THR;
            else if (c_low == 32'd4) kind = RG_CLAIM;
        end
    end
endmodule

// File: rtl/irqc_level_bank.sv
module irqc_level_bank
    import irqc_reg_pkg::*;
#(
    parameter int unsigned N    = 40,
    parameter int unsigned PW   = 3,
    parameter int unsigned MAXP = 7,
    parameter int unsigned AW   = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] ridx,
    output logic [PW-1:0] rval,
    output logic [N*PW-1:0] q
);
    logic [PW-1:0] lvl [N];
    logic          accept;
    logic [31:0]   folded;

    assign accept = level_accept(wdata, MAXP);
    assign folded = level_fold(wdata, MAXP);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) lvl[i] <= '0;
        end else if (we && accept && widx < N) begin
            lvl[widx] <= PW'(folded);
        end
    end

    assign rval = (ridx < N) ? lvl[ridx] : '0;

    generate
        for (genvar g = 0; g < N; g++) begin : g_flat
            assign q[g*PW +: PW] = lvl[g];
        end
    endgenerate
endmodule

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank #(
    parameter int unsigned NCTX = 2,
    parameter int unsigned NW   = 2,
    parameter int unsigned CTXW = 1,
    parameter int unsigned WW   = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [CTXW-1:0]        ctx,
    input  logic [WW-1:0]          word,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    output logic [NCTX*NW*32-1:0]  en_flat
);
    localparam int unsigned NE = NCTX * NW;

    logic [31:0] ew [NE];
    int unsigned sel;

    assign sel = 32'(ctx) * NW + 32'(word);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NE; i++) ew[i] <= '0;
        end else if (we && sel < NE) begin
            ew[sel] <= wdata;
        end
    end

    assign rdata = (sel < NE) ? ew[sel] : '0;

    generate
        for (genvar g = 0; g < NE; g++) begin : g_flat
            assign en_flat[g*32 +: 32] = ew[g];
        end
    endgenerate
endmodule

// File: rtl/irqc_reg_if.sv
module irqc_reg_if
    import irqc_reg_pkg::*;
#(
    parameter int unsigned NSRC       = 40,
    parameter int unsigned NCTX       = 2,
    parameter int unsigned MAX_PRIO   = 7,
    parameter int unsigned PRIO_BASE  = 32'h0000_0000,
    parameter int unsigned PEND_BASE  = 32'h0000_1000,
    parameter int unsigned ENA_BASE   = 32'h0000_2000,
    parameter int unsigned ENA_STRIDE = 32'h80,
    parameter int unsigned CTX_BASE   = 32'h0020_0000,
    parameter int unsigned CTX_STRIDE = 32'h1000,
    localparam int unsigned NW   = (NSRC + 31) / 32,
    localparam int unsigned PW   = (MAX_PRIO > 0) ? $clog2(MAX_PRIO + 1) : 1,
    localparam int unsigned IDW  = $clog2(NSRC),
    localparam int unsigned CTXW = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int unsigned WW   = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [31:0]           req_addr,
    input  logic [31:0]           req_wdata,
    output logic                  rsp_valid,
    output logic [31:0]           rsp_rdata,
    output logic                  rsp_err,
    input  logic [NSRC-1:0]       pend_i,
    output logic                  claim_o,
    output logic [CTXW-1:0]       claim_ctx_o,
    input  logic [IDW-1:0]        claim_id_i,
    output logic                  complete_o,
    output logic [CTXW-1:0]       complete_ctx_o,
    output logic [IDW-1:0]        complete_id_o,
    output logic [NSRC*PW-1:0]    prio_o,
    output logic [NCTX*PW-1:0]    thresh_o,
    output logic [NCTX*NW*32-1:0] enable_o
);
    region_e         kind;
    logic [IDW-1:0]  src_id;
    logic [CTXW-1:0] ctx;
    logic [WW-1:0]   word;
    logic            rd, wr, cmp_ok;
    logic [PW-1:0]   prio_rd, thr_rd;
    logic [31:0]     ena_rd;
    logic [NW*32-1:0] pend_pad;
    logic [31:0]     pend_word [NW];
    rsp_t            rsp_d, rsp_q;

    irqc_addr_decode #(
        .NSRC(NSRC), .NCTX(NCTX), .NW(NW),
        .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
        .ENA_BASE(ENA_BASE), .ENA_STRIDE(ENA_STRIDE),
        .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE),
        .IDW(IDW), .CTXW(CTXW), .WW(WW)
    ) u_dec (
        .addr(req_addr), .kind(kind), .src_id(src_id), .ctx(ctx), .word(word)
    );

    assign rd     = req_valid && !req_write;
    assign wr     = req_valid && req_write;
    assign cmp_ok = req_wdata < NSRC;

    irqc_level_bank #(.N(NSRC), .PW(PW), .MAXP(MAX_PRIO), .AW(IDW)) u_prio (
        .clk(clk), .rst(rst), .we(wr && kind == RG_PRIO), .widx(src_id),
        .wdata(req_wdata), .ridx(src_id), .rval(prio_rd), .q(prio_o)
    );

    irqc_level_bank #(.N(NCTX), .PW(PW), .MAXP(MAX_PRIO), .AW(CTXW)) u_thr (
        .clk(clk), .rst(rst), .we(wr && kind == RG_THR), .widx(ctx),
        .wdata(req_wdata), .ridx(ctx), .rval(thr_rd), .q(thresh_o)
    );

    irqc_enable_bank #(.NCTX(NCTX), .NW(NW), .CTXW(CTXW), .WW(WW)) u_ena (
        .clk(clk), .rst(rst), .we(wr && kind == RG_ENA), .ctx(ctx),
        .word(word), .wdata(req_wdata), .rdata(ena_rd), .en_flat(enable_o)
    );

    // source id 0 is reserved and never reported pending
    assign pend_pad = (NW*32)'({pend_i[NSRC-1:1], 1'b0});

    generate
        for (genvar g = 0; g < NW; g++) begin : g_pend
            assign pend_word[g] = pend_pad[g*32 +: 32];
        end
    endgenerate

    assign claim_o        = rd && kind == RG_CLAIM;
    assign claim_ctx_o    = ctx;
    assign complete_o     = wr && kind == RG_CLAIM && cmp_ok;
    assign complete_ctx_o = ctx;
    assign complete_id_o  = req_wdata[IDW-1:0];

    always_comb begin
        rsp_d.valid = req_valid;
        rsp_d.err   = 1'b0;
        rsp_d.data  = '0;
        if (req_valid) begin
            unique case (kind)
                RG_PRIO:  rsp_d.data = 32'(prio_rd);
                RG_PEND:  begin
                    rsp_d.data = (32'(word) < NW) ? pend_word[word] : '0;
                    rsp_d.err  = req_write;
                end
                RG_ENA:   rsp_d.data = ena_rd;
                RG_THR:   rsp_d.data = 32'(thr_rd);
                RG_CLAIM: begin
                    rsp_d.data = 32'(claim_id_i);
                    rsp_d.err  = req_write && !cmp_ok;
                end
                default:  rsp_d.err = 1'b1;
            endcase
            if (req_write || rsp_d.err) rsp_d.data = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.data;
endmodule

// File: rtl/irqc_reg_if_chk.sv
module irqc_reg_if_chk #(
    parameter int unsigned NSRC     = 40,
    parameter int unsigned MAX_PRIO = 7,
    parameter int unsigned PW       = 3,
    parameter int unsigned IDW      = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic              claim_o,
    input logic              complete_o,
    input logic [IDW-1:0]    complete_id_o,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [31:0]       rsp_rdata,
    input logic [NSRC*PW-1:0] prio_o
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);                                        // R10
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);                                      // R10
    AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_valid);                                          // R10
    AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> (!rsp_err || rsp_rdata == 32'd0)); // R10
    AST_CLAIM_ON_READ: assert property (@(posedge clk) disable iff (rst)
        claim_o |-> (req_valid && !req_write));                          // R7
    AST_COMPLETE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        complete_o |-> (req_valid && req_write && 32'(complete_id_o) < NSRC)); // R8
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(claim_o && complete_o));                                       // R7

    generate
        for (genvar g = 1; g < NSRC; g++) begin : g_lvl
            AST_PRIO_LEGAL: assert property (@(posedge clk) disable iff (rst)
                32'(prio_o[g*PW +: PW]) <= MAX_PRIO);                    // R2
        end
    endgenerate
endmodule

bind irqc_reg_if irqc_reg_if_chk #(
    .NSRC(NSRC), .MAX_PRIO(MAX_PRIO), .PW(PW), .IDW(IDW)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .claim_o(claim_o), .complete_o(complete_o), .complete_id_o(complete_id_o),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .prio_o(prio_o)
);

// File: tb/irqc_reg_if_tb.sv
module irqc_reg_if_tb;
    localparam int NSRC = 40, NCTX = 2, NW = 2, PW = 3, IDW = 6;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic [NSRC-1:0] pend = 0;

    logic rv0, re0, rv1, re1, clm0, clm1, cmp0, cmp1;
    logic [31:0] rd0, rd1;
    logic cctx0, cctx1, pctx0, pctx1;
    logic [IDW-1:0] cid0, cid1, pid0, pid1;
    logic [NSRC*PW-1:0] prio0, prio1;
    logic [NCTX*PW-1:0] thr0, thr1;
    logic [NCTX*NW*32-1:0] en0, en1;

    assign cid0 = IDW'(5 + 11 * cctx0);
    assign cid1 = IDW'(5 + 11 * cctx1);

    always #4 clk = ~clk;

    irqc_reg_if u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv0),
        .rsp_rdata(rd0), .rsp_err(re0), .pend_i(pend), .claim_o(clm0),
        .claim_ctx_o(cctx0), .claim_id_i(cid0), .complete_o(cmp0),
        .complete_ctx_o(pctx0), .complete_id_o(pid0), .prio_o(prio0),
        .thresh_o(thr0), .enable_o(en0));

    irqc_reg_if #(.MAX_PRIO(5)) u_dut_np (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv1),
        .rsp_rdata(rd1), .rsp_err(re1), .pend_i(pend), .claim_o(clm1),
        .claim_ctx_o(cctx1), .claim_id_i(cid1), .complete_o(cmp1),
        .complete_ctx_o(pctx1), .complete_id_o(pid1), .prio_o(prio1),
        .thresh_o(thr1), .enable_o(en1));

    int nchk = 0, nfail = 0;
    int unsigned pm [NSRC], pn [NSRC], tm [NCTX], tn [NCTX];
    logic [31:0] em [NCTX][NW];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pend_word(input int w);
        logic [63:0] p;
        p = 64'({pend[NSRC-1:1], 1'b0});
        return p[w*32 +: 32];
    endfunction

    // reference model; updates state on writes
    task automatic model(input bit w, input logic [31:0] a, input logic [31:0] d,
                         output logic [31:0] e0, output logic [31:0] e1, output bit ee,
                         output bit ec, output bit ep, output int ctx, output string rq);
        e0 = 0; e1 = 0; ee = 0; ec = 0; ep = 0; ctx = 0; rq = "R10";
        if (a[1:0] != 0) ee = 1;
        else if (a < 4 * (NSRC - 1)) begin
            int n = a / 4 + 1;
            rq = "R1/R2/R3";
            if (w) begin pm[n] = d % 8; if (d <= 5) pn[n] = d; end
            else begin e0 = pm[n]; e1 = pn[n]; end
        end else if (a >= 32'h1000 && a < 32'h1000 + 4 * NW) begin
            rq = "R5";
            if (w) ee = 1; else begin e0 = pend_word((a - 32'h1000) / 4); e1 = e0; end
        end else if (a >= 32'h2000 && a < 32'h2000 + NCTX * 32'h80) begin
            int wd = ((a - 32'h2000) % 32'h80) / 4;
            ctx = (a - 32'h2000) / 32'h80; rq = "R6";
            if (wd >= NW) ee = 1;
            else if (w) em[ctx][wd] = d;
            else begin e0 = em[ctx][wd]; e1 = e0; end
        end else if (a >= 32'h200000 && a < 32'h200000 + NCTX * 32'h1000) begin
            int off = (a - 32'h200000) % 32'h1000;
            ctx = (a - 32'h200000) / 32'h1000;
            if (off == 0) begin
                rq = "R4/R2/R3";
                if (w) begin tm[ctx] = d % 8; if (d <= 5) tn[ctx] = d; end
                else begin e0 = tm[ctx]; e1 = tn[ctx]; end
            end else if (off == 4) begin
                if (w) begin rq = "R8"; if (d < NSRC) ep = 1; else ee = 1; end
                else begin rq = "R7"; ec = 1; e0 = 5 + 11 * ctx; e1 = e0; end
            end else begin rq = "R9"; ee = 1; end
        end else ee = 1;
    endtask

    // drive one request a little after a rising edge, check pulses, then the response
    task automatic acc(input bit w, input logic [31:0] a, input logic [31:0] d);
        logic [31:0] e0, e1; bit ee, ec, ep; int c; string rq;
        model(w, a, d, e0, e1, ee, ec, ep, c, rq);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        #1;
        chk(clm0 == ec && clm1 == ec, {rq, " claim pulse"}, clm0, ec);
        if (ec) chk(cctx0 == c, "R7 claim ctx", cctx0, c);
        chk(cmp0 == ep && cmp1 == ep, {rq, " complete pulse"}, cmp0, ep);
        if (ep) chk(pctx0 == c && pid0 == d[IDW-1:0], "R8 complete ctx/id",
                    {pctx0, pid0}, {c[0], d[IDW-1:0]});
        @(posedge clk); #1;
        req_valid = 0;
        chk(rv0 == 1 && rv1 == 1, "R10 rsp_valid", rv0, 1);
        chk(re0 == ee && re1 == ee, {rq, " rsp_err"}, re0, ee);
        chk(rd0 == e0, {rq, " rdata"}, rd0, e0);
        chk(rd1 == e1, {rq, " rdata (non-pow2 instance)"}, rd1, e1);
    endtask

    function automatic logic [31:0] rand_addr();
        int unsigned k = $urandom_range(0, 9);
        case (k)
            0, 1: return 4 * $urandom_range(0, NSRC - 2);
            2:    return 32'h1000 + 4 * $urandom_range(0, NW - 1);
            3, 4: return 32'h2000 + 32'h80 * $urandom_range(0, 1) + 4 * $urandom_range(0, 3);
            5, 6: return 32'h200000 + 32'h1000 * $urandom_range(0, 1) + 4 * $urandom_range(0, 3);
            7:    return 32'h200000 + 32'h1000 * $urandom_range(0, 1) + 4;
            8:    return (4 * $urandom_range(0, NSRC - 2)) | $urandom_range(1, 3);
            default: return 32'h300000 + 4 * $urandom_range(0, 15);
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < NSRC; i++) begin pm[i] = 0; pn[i] = 0; end
        for (int c = 0; c < NCTX; c++) begin
            tm[c] = 0; tn[c] = 0;
            for (int w = 0; w < NW; w++) em[c][w] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R11 reset state
        chk(rv0 == 0, "R11 rsp_valid after reset", rv0, 0);
        chk(prio0 == 0 && thr0 == 0, "R11 priority/threshold reset", {prio0[63:0]}, 0);
        chk(en0 == 0, "R11 enable reset", en0[63:0], 0);
        acc(0, 32'h0, 0);
        // R1 / R2 / R3 directed on source 39
        acc(1, 4 * 38, 13);
        chk(prio0[39*PW +: PW] == 5, "R2 fold 13 mod 8 on prio_o", prio0[39*PW +: PW], 5);
        chk(prio1[39*PW +: PW] == 0, "R3 refuse 13 keeps 0", prio1[39*PW +: PW], 0);
        acc(1, 4 * 38, 5);
        acc(1, 4 * 38, 7);
        chk(prio1[39*PW +: PW] == 5, "R3 refuse 7 keeps 5", prio1[39*PW +: PW], 5);
        chk(prio0[0 +: PW] == 0, "R1 source 0 slot zero", prio0[0 +: PW], 0);
        acc(0, 4 * 38, 0);
        // R4 threshold on context 1
        acc(1, 32'h201000, 9);
        chk(thr0[PW +: PW] == 1 && thr1[PW +: PW] == 0, "R4 threshold outputs",
            {thr0[PW +: PW], thr1[PW +: PW]}, {3'd1, 3'd0});
        // R6 enable word and out-of-range word
        acc(1, 32'h2084, 32'hA5A5_0F0F);
        chk(en0[(1*NW+1)*32 +: 32] == 32'hA5A5_0F0F, "R6 enable_o word", en0[(1*NW+1)*32 +: 32], 32'hA5A5_0F0F);
        acc(1, 32'h2088, 32'hFFFF_FFFF);
        acc(0, 32'h2088, 0);
        // R5 pending read, write ignored
        pend = 40'hFF_1234_5679;
        acc(0, 32'h1000, 0);
        acc(1, 32'h1004, 32'hFFFF_FFFF);
        acc(0, 32'h1004, 0);
        // R7 / R8 / R9 claim, complete, bad offset
        acc(0, 32'h200004, 0);
        acc(0, 32'h201004, 0);
        acc(1, 32'h201004, 39);
        acc(1, 32'h200004, 40);
        acc(1, 32'h200008, 1);
        acc(0, 32'h20100C, 0);
        // R10 misaligned and unmapped
        acc(1, 32'h0000_0002, 3);
        acc(0, 32'h0000_0002, 0);
        acc(0, 32'h0030_0000, 0);
        // random phase
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a = rand_addr();
            bit w = $urandom_range(0, 1) == 1;
            logic [31:0] d = ($urandom_range(0, 3) == 0) ? $urandom : $urandom_range(0, 47);
            pend = {$urandom, $urandom};
            acc(w, a, d);
        end
        // final output vectors against model
        for (int n = 1; n < NSRC; n++)
            chk(prio0[n*PW +: PW] == pm[n] && prio1[n*PW +: PW] == pn[n], "R1 prio_o vector",
                {prio0[n*PW +: PW], prio1[n*PW +: PW]}, {pm[n][2:0], pn[n][2:0]});
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule